// File: doc/BRIEF.md
# Flash Command and Status Front End

This block is the register-level control front end of a parallel NOR-style flash device. Software writes command bytes over an 8-bit bus. A write counts only in a clock cycle where chip select and write strobe are both low. The block decodes these bytes into read modes, a status clear, and two-step program and erase operations. Memory contents change only when the second step of such a pair arrives. A simplified write engine then runs for a fixed, parameterised number of cycles before it commits the change to a small behavioural word array.

A status byte reports four things:
- engine ready (bit 7);
- a sticky low programming-voltage flag (bit 3);
- a program error (bit 4);
- an erase error (bit 5).

While the low-voltage flag is set, program and erase attempts are refused until software clears the flags. The active-low reset/power-down input aborts any running operation. It returns the status byte to 80h and puts the read mode back to array. The power-up reset does the same and also fills the array with FFh. After an operation ends, the bus keeps showing status until software writes the read-array command.

Top module: `flash_cmd_front`

## Requirements
- R1: A command byte is taken only in a clock cycle where `ce_n` and `we_n` are both low and `rp_n` is high. Holding either strobe high leaves the read mode and the array untouched.
- R2: `dout_en` is 1 exactly when `ce_n` and `oe_n` are low and `rp_n` is high.
- R3: After power-up reset, reads return array data and every word reads FFh. Command FFh selects array reads and command 70h selects status reads. The status byte is {ready, 0, erase_err, prog_err, vpp_err, 000}.
- R4: Program is 40h followed by a data write. The data write's `din` and `addr` give the word and the location. A single data write without the 40h setup changes nothing.
- R5: Erase is 20h followed by D0h, and it sets every word to FFh. If the second write is anything other than D0h, bits 4 and 5 are set and the array is unchanged.
- R6: Ready (bit 7) reads 0 for exactly `BUSY_CYC` cycles after a valid confirm, then returns to 1.
- R7: If `vpp_ok` is low at the confirm, or drops while the engine is busy, the operation does not commit. Bit 3 is set, together with bit 4 for a program or bit 5 for an erase.
- R8: While bit 3 is set, a program or erase pair is refused and the engine never goes busy. A refused program sets bit 4 and a refused erase sets bit 5.
- R9: Command 50h clears bits 3, 4 and 5 and leaves the read mode unchanged.
- R10: Driving `rp_n` low aborts a running operation without committing it. The status byte becomes 80h, the read mode returns to array, and `dout_en` is forced low.
- R11: The second write of a pair selects status reads. Status stays selected after the operation ends, until FFh is written.
- R12: `vpp_ok` transitions and `ce_n` toggles that occur without a write leave the read mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| rp_n | input | 1 | Reset/power-down, active low |
| vpp_ok | input | 1 | Programming voltage is valid |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable request, active low |
| addr | input | AW | Word address |
| din | input | 8 | Command / write data byte |
| dout | output | 8 | Array word or status byte |
| dout_en | output | 1 | Bus drive enable; the bus is high impedance when 0 |

## Verification
The read path is combinational. The bench therefore samples `dout` and `dout_en` one nanosecond after it changes `addr`, `ce_n` or `oe_n`, and does so in the low phase of the clock. A command write takes effect at the rising edge that captures it, so the next read in the following low phase already reflects the new mode or flags.

The ready bit falls at the confirm edge and rises `BUSY_CYC` edges later. The bench polls once per falling edge, beginning at the falling edge right after the confirm, and expects exactly `BUSY_CYC` polls that see busy. An abort from `vpp_ok` or `rp_n` is applied at a falling edge and checked one edge later.

// File: rtl/flash_cmd_front.sv
module flash_cmd_front #(
  parameter int AW       = 3,
  parameter int BUSY_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rp_n,
  input  logic          vpp_ok,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_en
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(BUSY_CYC + 1);
  localparam logic [1:0] P_NONE = 2'd0, P_PROG = 2'd1, P_ERASE = 2'd2;

  logic [7:0]    mem [DEPTH];
  logic          rd_sts, busy, op_erase;
  logic [1:0]    pend;
  logic [2:0]    err;
  logic [CW-1:0] cnt;
  logic [AW-1:0] t_addr;
  logic [7:0]    t_data;
  logic [DEPTH*8-1:0] mem_flat;

  wire       wr   = !ce_n && !we_n;
  wire       done = busy && (cnt == '0) && vpp_ok;
  wire [7:0] sts  = {!busy, 1'b0, err[2], err[1], err[0], 3'b000};

  assign dout    = rd_sts ? sts : mem[addr];
  assign dout_en = !ce_n && !oe_n && rp_n;

  for (genvar i = 0; i < DEPTH; i++) begin : g_flat
    assign mem_flat[i*8 +: 8] = mem[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (rp_n && done) begin
      if (op_erase) for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      else mem[t_addr] <= t_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sts <= 1'b0; busy <= 1'b0; op_erase <= 1'b0; pend <= P_NONE;
      err <= '0; cnt <= '0; t_addr <= '0; t_data <= '0;
    end else if (!rp_n) begin
      rd_sts <= 1'b0; busy <= 1'b0; pend <= P_NONE; err <= '0; cnt <= '0;
    end else if (busy) begin
      if (!vpp_ok) begin
        busy   <= 1'b0;
        err[0] <= 1'b1;
        if (op_erase) err[2] <= 1'b1;
        else          err[1] <= 1'b1;
      end else if (cnt == '0) busy <= 1'b0;
      else cnt <= cnt - 1'b1;
      if (wr && din == 8'hFF)      rd_sts <= 1'b0;
      else if (wr && din == 8'h70) rd_sts <= 1'b1;
    end else if (wr) begin
      case (pend)
        P_PROG: begin
          pend <= P_NONE; rd_sts <= 1'b1;
          if (err[0]) err[1] <= 1'b1;
          else if (!vpp_ok) begin err[0] <= 1'b1; err[1] <= 1'b1; end
          else begin
            busy <= 1'b1; op_erase <= 1'b0; cnt <= CW'(BUSY_CYC - 1);
            t_addr <= addr; t_data <= din;
          end
        end
        P_ERASE: begin
          pend <= P_NONE; rd_sts <= 1'b1;
          if (din != 8'hD0) err[2:1] <= 2'b11;
          else if (err[0]) err[2] <= 1'b1;
          else if (!vpp_ok) begin err[0] <= 1'b1; err[2] <= 1'b1; end
          else begin
            busy <= 1'b1; op_erase <= 1'b1; cnt <= CW'(BUSY_CYC - 1);
          end
        end
        default: begin
          case (din)
            8'hFF: rd_sts <= 1'b0;
            8'h70: rd_sts <= 1'b1;
            8'h50: err <= '0;
            8'h40: begin pend <= P_PROG;  rd_sts <= 1'b1; end
            8'h20: begin pend <= P_ERASE; rd_sts <= 1'b1; end
            default: ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_front_chk.sv
module flash_cmd_front_chk #(
  parameter int AW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rp_n,
  input logic                 vpp_ok,
  input logic                 ce_n,
  input logic                 we_n,
  input logic                 busy,
  input logic [7:0]           sts,
  input logic [(1<<AW)*8-1:0] mem_flat
);
  AST_RP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |=> (sts == 8'h80)); // R10
  AST_ARRAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(mem_flat)); // R4
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[3] && !busy) |=> !busy); // R8
  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!ce_n && !we_n && rp_n)); // R1
  AST_ABORT_VPP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !vpp_ok && rp_n) |=> (!busy && sts[3])); // R7
endmodule

bind flash_cmd_front flash_cmd_front_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .vpp_ok(vpp_ok), .ce_n(ce_n),
  .we_n(we_n), .busy(busy), .sts(sts), .mem_flat(mem_flat)
);

// File: tb/test_flash_cmd_front.sv
`timescale 1ns/100ps
module test_flash_cmd_front;
  localparam int AW = 3, B = 6, DEPTH = 1 << AW;
  logic clk = 0, rst_n = 0, rp_n = 1, vpp_ok = 1, ce_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic dout_en;
  int checks = 0, fails = 0;
  logic [7:0] em [DEPTH];
  logic [7:0] v;
  int n;

  flash_cmd_front #(.AW(AW), .BUSY_CYC(B)) i_flash_cmd_front (.*);

  always #2 clk = ~clk;

  task automatic chk(input int got, input int exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wc(input logic [7:0] d, input logic [AW-1:0] a = '0);
    @(negedge clk); ce_n = 0; we_n = 0; din = d; addr = a;
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] r);
    addr = a; ce_n = 0; oe_n = 0; #1; r = dout; ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_ready(output int cnt);
    cnt = 0; ce_n = 0; oe_n = 0; #1;
    while (!dout[7] && cnt < 1000) begin cnt++; @(negedge clk); #1; end
    ce_n = 1; oe_n = 1;
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) em[i] = 8'hFF;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state: array mode, all FF, status 80
    for (int a = 0; a < DEPTH; a++) begin rd(a[AW-1:0], v); chk(v, 8'hFF, "R3 reset array"); end
    wc(8'h70); rd(0, v); chk(v, 8'h80, "R3 status after reset");
    wc(8'hFF);
    // R2 output enable sweep
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); ce_n = k[0]; oe_n = k[1]; rp_n = k[2]; #1;
      chk(dout_en, (!k[0] && !k[1] && k[2]) ? 1 : 0, "R2 dout_en");
      rp_n = 1; ce_n = 1; oe_n = 1;
    end
    // R1 strobe sweep with 70h
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); ce_n = k[0]; we_n = k[1]; din = 8'h70;
      @(negedge clk); ce_n = 1; we_n = 1;
      rd(0, v); chk(v, (k == 0) ? 8'h80 : 8'hFF, "R1 strobe gating");
      wc(8'hFF);
    end
    // R4 single data write without setup
    wc(8'h12, 1); rd(1, v); chk(v, 8'hFF, "R4 no setup no change");
    // R4/R6/R11 program sweep
    for (int a = 0; a < DEPTH; a++) begin
      em[a] = 8'((a * 37 + 5) & 8'hFF);
      wc(8'h40); wc(em[a], a[AW-1:0]);
      wait_ready(n); chk(n, B, "R6 busy length");
      rd(0, v); chk(v, 8'h80, "R11 status held");
    end
    wc(8'hFF);
    for (int a = 0; a < DEPTH; a++) begin rd(a[AW-1:0], v); chk(v, em[a], "R4 program data"); end
    // R5 erase
    wc(8'h20); wc(8'hD0); wait_ready(n); chk(n, B, "R6 erase busy length");
    wc(8'hFF);
    for (int a = 0; a < DEPTH; a++) begin em[a] = 8'hFF; rd(a[AW-1:0], v); chk(v, 8'hFF, "R5 erased"); end
    for (int a = 0; a < DEPTH; a++) begin
      em[a] = 8'(8'hA0 ^ a); wc(8'h40); wc(em[a], a[AW-1:0]); wait_ready(n);
    end
    wc(8'h20); wc(8'h55); rd(0, v); chk(v, 8'hB0, "R5 bad confirm");
    wc(8'h50); rd(0, v); chk(v, 8'h80, "R9 clear keeps status mode");
    wc(8'hFF); rd(2, v); chk(v, em[2], "R5 bad confirm no erase");
    // R7 vpp low at confirm, R8 lockout, R9 clear
    vpp_ok = 0; wc(8'h40); wc(8'hAA, 3); rd(0, v); chk(v, 8'h98, "R7 vpp low at confirm");
    vpp_ok = 1;
    wc(8'h40); wc(8'h55, 3); rd(0, v); chk(v, 8'h98, "R8 program refused");
    wc(8'h20); wc(8'hD0); rd(0, v); chk(v, 8'hB8, "R8 erase refused");
    wc(8'h50); rd(0, v); chk(v, 8'h80, "R9 flags cleared");
    wc(8'hFF); rd(3, v); chk(v, em[3], "R8 array untouched");
    // R7 vpp drop while busy
    wc(8'h40); wc(8'h11, 4);
    repeat (2) @(negedge clk);
    vpp_ok = 0; @(negedge clk); vpp_ok = 1;
    rd(0, v); chk(v, 8'h98, "R7 abort during busy");
    wc(8'h50); wc(8'hFF); rd(4, v); chk(v, em[4], "R7 no commit");
    // R10 rp_n abort
    wc(8'h40); wc(8'h22, 5);
    repeat (2) @(negedge clk);
    rp_n = 0; ce_n = 0; oe_n = 0; #1; chk(dout_en, 0, "R10 bus off");
    ce_n = 1; oe_n = 1;
    @(negedge clk); rp_n = 1;
    repeat (B + 2) @(negedge clk);
    rd(5, v); chk(v, em[5], "R10 array mode and no commit");
    wc(8'h70); rd(0, v); chk(v, 8'h80, "R10 status 80");
    // R12 vpp and ce toggles without write keep status mode
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); vpp_ok = k[0]; ce_n = k[1];
    end
    @(negedge clk); vpp_ok = 1; ce_n = 1;
    rd(0, v); chk(v, 8'h80, "R12 mode kept");
    wc(8'hFF); rd(0, v); chk(v, em[0], "R11 FF returns array");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule